// File: doc/BRIEF.md
# Prescaled Seconds Counter with Alarm

This block is a slow real-time counter with a 16-bit register interface. A programmable prescaler divides pulses of a slow timebase, presented as a one-cycle enable `slow_en` inside the single system clock domain, into a periodic tick. Each tick advances a 32-bit seconds counter. When the counter reaches a programmed 32-bit alarm value, an alarm flag is raised.

The counter, prescaler reload and alarm are protected. Software sets a configuration-mode bit, writes staged copies of those registers, and then clears the bit. Clearing the bit commits all staged values in one step. Every accepted register write makes the block busy for a short commit window, and a write-done bit reports when that window has ended. Software polls this bit before it issues the next write.

The block keeps four sticky flags: second, alarm, overflow and synchronised. Software clears a flag by writing 0 to its bit. Three interrupt outputs are formed by gating the second, alarm and overflow flags with their enable bits.

Top module: `slow_second_timer`

## Requirements
- R1: After reset, CTRL (address 0) reads 0x0020: only write-done (bit 5) is set. IEN (address 1) reads 0. CNT_HI (4) and CNT_LO (5) read 0. PRE_HI (2) and PRE_LO (3) hold the reload reset value PRE_RST split into a high part and a low 16-bit part.
- R2: With a reload of N, the counter increases by exactly 1 on every (N+1)-th `slow_en` pulse, and the second flag (CTRL bit 0) is set on each such tick. The divider restarts from the reload value at every configuration commit.
- R3: A tick at counter value 0xFFFFFFFF wraps the counter to 0 and sets the overflow flag (CTRL bit 2).
- R4: Writes to PRE_HI, PRE_LO, CNT_HI, CNT_LO, ALM_HI (6) and ALM_LO (7) have no effect while the configuration bit (CTRL bit 4) is 0. Inside configuration mode these writes are staged. They take effect only when a CTRL write clears bit 4.
- R5: After each accepted write, write-done (CTRL bit 5) reads 0 for exactly BUSY_CYC cycles. Any write issued while it is 0 is ignored.
- R6: ALM_HI and ALM_LO always read 0.
- R7: The alarm flag (CTRL bit 1) is set when the counter changes to a value equal to the alarm. Writing 0 to a flag bit in CTRL clears that flag. Writing 1 leaves it unchanged. If hardware sets a flag in the same cycle that software clears it, the set wins.
- R8: Each interrupt output equals its flag ANDed with its enable in IEN: bit 0 for second, bit 1 for alarm, bit 2 for overflow.
- R9: The synchronised flag (CTRL bit 3) is cleared by software and is set again by hardware on the next tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| slow_en | input | 1 | One-cycle pulse per slow timebase period |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr` (combinational) |
| irq_second | output | 1 | Second flag AND its enable |
| irq_alarm | output | 1 | Alarm flag AND its enable |
| irq_overflow | output | 1 | Overflow flag AND its enable |

## Verification
The bench overrides PRE_RST to 4 and keeps BUSY_CYC at 3 and PRE_W at 20. With these values the reset-value check of the reload stays short. Software-programmed reloads of 2 and 0 bring the tick spacing, an alarm hit and a 32-bit wrap within a few dozen `slow_en` pulses. With a busy window of 3 cycles, the bench can probe each cycle of the window and can place a write in the middle of it to show that the write is dropped.

// File: rtl/sst_pkg.sv
// Package: shared register addresses and control-bit positions for the
// prescaled seconds counter. Assumes a 16-bit register bus.
package sst_pkg;
    localparam int BUS_W = 16;

    typedef enum logic [2:0] {
        A_CTRL   = 3'd0,
        A_IEN    = 3'd1,
        A_PRE_HI = 3'd2,
        A_PRE_LO = 3'd3,
        A_CNT_HI = 3'd4,
        A_CNT_LO = 3'd5,
        A_ALM_HI = 3'd6,
        A_ALM_LO = 3'd7
    } reg_addr_e;

    localparam int CB_SEC  = 0;
    localparam int CB_ALM  = 1;
    localparam int CB_OVF  = 2;
    localparam int CB_SYN  = 3;
    localparam int CB_CFG  = 4;
    localparam int CB_DONE = 5;

    localparam int IB_SEC = 0;
    localparam int IB_ALM = 1;
    localparam int IB_OVF = 2;
endpackage

// File: rtl/sst_wr_gate.sv
// Write gate: accepts a write only when idle, then holds write-done low for
// BUSY_CYC cycles to model the commit latency. Assumes BUSY_CYC >= 1.
module sst_wr_gate #(
    parameter int BUSY_CYC = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_req,
    output logic accept,
    output logic done
);
    localparam int CW = $clog2(BUSY_CYC + 1);

    logic [CW-1:0] busy_q;

    assign done   = (busy_q == '0);
    assign accept = wr_req && done;

    // Load the busy window on an accepted write, count down otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)
            busy_q <= '0;
        else if (accept)
            busy_q <= CW'(BUSY_CYC);
        else if (!done)
            busy_q <= busy_q - 1'b1;
    end

    // R5: an accepted write makes the gate busy in the next cycle
    p_busy_after_accept_r5: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !done);
endmodule

// File: rtl/sst_prescaler.sv
// Prescaler: counts slow_en pulses down from the reload value and emits a
// one-cycle tick when the divider is at zero. A restart reloads the divider
// from restart_val and suppresses the tick in that cycle.
module sst_prescaler #(
    parameter int          PRE_W   = 20,
    parameter logic [PRE_W-1:0] RST_VAL = PRE_W'(32'h7FFF)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             slow_en,
    input  logic [PRE_W-1:0] reload,
    input  logic             restart,
    input  logic [PRE_W-1:0] restart_val,
    output logic             tick
);
    logic [PRE_W-1:0] div_q;

    assign tick = slow_en && !restart && (div_q == '0);

    // Divider: restart, reload at zero, or step down on each slow pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)
            div_q <= RST_VAL;
        else if (restart)
            div_q <= restart_val;
        else if (slow_en)
            div_q <= (div_q == '0) ? reload : div_q - 1'b1;
    end

    // R2: the divider never exceeds the live reload value
    p_div_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        div_q <= reload);
endmodule

// File: rtl/sst_counter.sv
// Seconds counter: increments on tick, loads on commit (load has priority),
// and reports the next value, an update strobe and a wrap pulse.
module sst_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] cnt,
    output logic [W-1:0] cnt_next,
    output logic         upd,
    output logic         wrap
);
    assign upd      = load || tick;
    assign cnt_next = load ? load_val : cnt + 1'b1;
    assign wrap     = tick && !load && (cnt == '1);

    // Counter register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (upd)
            cnt <= cnt_next;
    end

    // R2: a plain tick advances the count by exactly one
    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tick && !load |=> cnt == $past(cnt) + 1'b1);
    // R3: a wrap lands on zero
    p_wrap_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> cnt == '0);
endmodule

// File: rtl/sst_alarm.sv
// Alarm holder: keeps the live alarm value (loaded on commit) and flags a hit
// when the counter is updated to a value equal to the current alarm.
module sst_alarm #(
    parameter int          W       = 32,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         commit,
    input  logic [W-1:0] commit_val,
    input  logic         upd,
    input  logic [W-1:0] cnt_next,
    output logic [W-1:0] alarm_val,
    output logic         hit
);
    assign hit = upd && (cnt_next == alarm_val);

    // Live alarm register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            alarm_val <= RST_VAL;
        else if (commit)
            alarm_val <= commit_val;
    end
endmodule

// File: rtl/slow_second_timer.sv
// Top: register file for the prescaled seconds counter. Protected registers
// are staged in shadows during configuration mode and committed when the
// mode bit is cleared. Assumes 16 < PRE_W < 32 and a single clock domain.
module slow_second_timer
    import sst_pkg::*;
#(
    parameter int              PRE_W    = 20,
    parameter logic [PRE_W-1:0] PRE_RST  = PRE_W'(32'h7FFF),
    parameter logic [31:0]     ALM_RST  = 32'hFFFF_FFFF,
    parameter int              BUSY_CYC = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        slow_en,
    input  logic        reg_wr,
    input  logic [2:0]  reg_addr,
    input  logic [15:0] reg_wdata,
    output logic [15:0] reg_rdata,
    output logic        irq_second,
    output logic        irq_alarm,
    output logic        irq_overflow
);
    localparam int CNT_W    = 2 * BUS_W;
    localparam int PRE_HI_W = PRE_W - BUS_W;

    logic             accept, done;
    logic             cfg_q;
    logic             sec_f, alm_f, ovf_f, syn_f;
    logic             ie_sec, ie_alm, ie_ovf;
    logic [PRE_W-1:0] pre_live, pre_sh;
    logic [CNT_W-1:0] cnt_sh, alm_sh;
    logic             cnt_dirty;
    logic [CNT_W-1:0] cnt, cnt_next, alm_live;
    logic             upd, wrap, tick, hit;
    logic             wr_ctrl, enter, commit, cfg_wr;
    reg_addr_e        addr;

    assign addr    = reg_addr_e'(reg_addr);
    assign wr_ctrl = accept && (addr == A_CTRL);
    assign enter   = wr_ctrl && reg_wdata[CB_CFG] && !cfg_q;
    assign commit  = wr_ctrl && !reg_wdata[CB_CFG] && cfg_q;
    assign cfg_wr  = accept && cfg_q;

    sst_wr_gate #(.BUSY_CYC(BUSY_CYC)) u_gate (
        .clk(clk), .rst_n(rst_n), .wr_req(reg_wr), .accept(accept), .done(done)
    );

    sst_prescaler #(.PRE_W(PRE_W), .RST_VAL(PRE_RST)) u_pre (
        .clk(clk), .rst_n(rst_n), .slow_en(slow_en), .reload(pre_live),
        .restart(commit), .restart_val(pre_sh), .tick(tick)
    );

    sst_counter #(.W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .load(commit && cnt_dirty),
        .load_val(cnt_sh), .cnt(cnt), .cnt_next(cnt_next), .upd(upd), .wrap(wrap)
    );

    sst_alarm #(.W(CNT_W), .RST_VAL(ALM_RST)) u_alm (
        .clk(clk), .rst_n(rst_n), .commit(commit), .commit_val(alm_sh),
        .upd(upd), .cnt_next(cnt_next), .alarm_val(alm_live), .hit(hit)
    );

    // Configuration-mode bit follows every accepted CTRL write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg_q <= 1'b0;
        else if (wr_ctrl)
            cfg_q <= reg_wdata[CB_CFG];
    end

    // Shadow copies: snapshot on entry, staged writes inside configuration mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_sh    <= PRE_RST;
            cnt_sh    <= '0;
            alm_sh    <= ALM_RST;
            cnt_dirty <= 1'b0;
        end else if (enter) begin
            pre_sh    <= pre_live;
            cnt_sh    <= cnt;
            alm_sh    <= alm_live;
            cnt_dirty <= 1'b0;
        end else if (cfg_wr) begin
            unique case (addr)
                A_PRE_HI: pre_sh[PRE_W-1:BUS_W] <= reg_wdata[PRE_HI_W-1:0];
                A_PRE_LO: pre_sh[BUS_W-1:0]     <= reg_wdata;
                A_CNT_HI: begin
                    cnt_sh[CNT_W-1:BUS_W] <= reg_wdata;
                    cnt_dirty             <= 1'b1;
                end
                A_CNT_LO: begin
                    cnt_sh[BUS_W-1:0] <= reg_wdata;
                    cnt_dirty         <= 1'b1;
                end
                A_ALM_HI: alm_sh[CNT_W-1:BUS_W] <= reg_wdata;
                A_ALM_LO: alm_sh[BUS_W-1:0]     <= reg_wdata;
                default: ;
            endcase
        end
    end

    // Live prescaler reload, updated only by a commit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pre_live <= PRE_RST;
        else if (commit)
            pre_live <= pre_sh;
    end

    // Sticky flags: hardware set wins over a software write of 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sec_f <= 1'b0;
            alm_f <= 1'b0;
            ovf_f <= 1'b0;
            syn_f <= 1'b0;
        end else begin
            sec_f <= tick | (sec_f & ~(wr_ctrl & ~reg_wdata[CB_SEC]));
            alm_f <= hit  | (alm_f & ~(wr_ctrl & ~reg_wdata[CB_ALM]));
            ovf_f <= wrap | (ovf_f & ~(wr_ctrl & ~reg_wdata[CB_OVF]));
            syn_f <= tick | (syn_f & ~(wr_ctrl & ~reg_wdata[CB_SYN]));
        end
    end

    // Interrupt enables.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ie_sec <= 1'b0;
            ie_alm <= 1'b0;
            ie_ovf <= 1'b0;
        end else if (accept && addr == A_IEN) begin
            ie_sec <= reg_wdata[IB_SEC];
            ie_alm <= reg_wdata[IB_ALM];
            ie_ovf <= reg_wdata[IB_OVF];
        end
    end

    assign irq_second   = sec_f & ie_sec;
    assign irq_alarm    = alm_f & ie_alm;
    assign irq_overflow = ovf_f & ie_ovf;

    // Read multiplexer; the alarm addresses return zero.
    always_comb begin
        reg_rdata = '0;
        unique case (addr)
            A_CTRL: begin
                reg_rdata[CB_SEC]  = sec_f;
                reg_rdata[CB_ALM]  = alm_f;
                reg_rdata[CB_OVF]  = ovf_f;
                reg_rdata[CB_SYN]  = syn_f;
                reg_rdata[CB_CFG]  = cfg_q;
                reg_rdata[CB_DONE] = done;
            end
            A_IEN: begin
                reg_rdata[IB_SEC] = ie_sec;
                reg_rdata[IB_ALM] = ie_alm;
                reg_rdata[IB_OVF] = ie_ovf;
            end
            A_PRE_HI: reg_rdata[PRE_HI_W-1:0] = pre_live[PRE_W-1:BUS_W];
            A_PRE_LO: reg_rdata = pre_live[BUS_W-1:0];
            A_CNT_HI: reg_rdata = cnt[CNT_W-1:BUS_W];
            A_CNT_LO: reg_rdata = cnt[BUS_W-1:0];
            default:  reg_rdata = '0;
        endcase
    end

    // R4: outside configuration mode the protected live values hold
    p_cfg_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_q |=> $stable(alm_live) && $stable(pre_live));
    // R5: a write during the busy window changes no register
    p_ignore_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr && !done |=> $stable(cfg_q) && $stable({ie_sec, ie_alm, ie_ovf}));
    // R7: the alarm flag only rises when the counter reached the alarm
    p_alarm_match_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alm_f) |-> cnt == $past(alm_live));
    // R8: no alarm interrupt without its enable
    p_irq_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_alarm |-> ie_alm);
    // R9: the synchronised flag only rises after a tick
    p_sync_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(syn_f) |-> $past(tick));
endmodule

// File: tb/slow_second_timer_tb.sv
`timescale 1ns/1ps
module slow_second_timer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n, slow_en, reg_wr;
    logic [2:0]  reg_addr;
    logic [15:0] reg_wdata, reg_rdata;
    logic        irq_second, irq_alarm, irq_overflow;
    int          n_chk = 0;
    int          n_fail = 0;
    bit          finished = 1'b0;

    always #2.5 clk = ~clk;

    slow_second_timer #(.PRE_RST(20'd4)) dut_i (
        .clk(clk), .rst_n(rst_n), .slow_en(slow_en), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_second(irq_second), .irq_alarm(irq_alarm), .irq_overflow(irq_overflow)
    );

    localparam logic [1:0] OP_WR = 2'd0;
    localparam logic [1:0] OP_RD = 2'd1;
    localparam int NV = 13;
    // {op, addr, data}: R4 staging and commit, R6 alarm read-back
    localparam logic [20:0] VEC [NV] = '{
        {OP_WR, 3'd0, 16'h0010},
        {OP_WR, 3'd2, 16'h0000},
        {OP_WR, 3'd3, 16'h0002},
        {OP_WR, 3'd4, 16'h0000},
        {OP_WR, 3'd5, 16'h0005},
        {OP_WR, 3'd6, 16'h0000},
        {OP_WR, 3'd7, 16'h0007},
        {OP_RD, 3'd5, 16'h0000},
        {OP_RD, 3'd3, 16'h0004},
        {OP_WR, 3'd0, 16'h0000},
        {OP_RD, 3'd5, 16'h0005},
        {OP_RD, 3'd3, 16'h0002},
        {OP_RD, 3'd7, 16'h0000}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic peek(input logic [2:0] a, output logic [15:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        peek(a, d);
    endtask

    task automatic wait_done();
        logic [15:0] d;
        peek(3'd0, d);
        while (!d[5]) begin
            @(negedge clk);
            peek(3'd0, d);
        end
    endtask

    task automatic wr_raw(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        wait_done();
        wr_raw(a, d);
    endtask

    task automatic pulses(input int n);
        repeat (n) begin
            @(negedge clk); slow_en = 1'b1;
            @(negedge clk); slow_en = 1'b0;
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [15:0] d;
        rst_n = 1'b0; slow_en = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(3'd0, d); check("R1 ctrl", d, 16'h0020);
        rd(3'd1, d); check("R1 ien", d, 16'h0000);
        rd(3'd4, d); check("R1 cnt_hi", d, 16'h0000);
        rd(3'd5, d); check("R1 cnt_lo", d, 16'h0000);
        rd(3'd2, d); check("R1 pre_hi", d, 16'h0000);
        rd(3'd3, d); check("R1 pre_lo", d, 16'h0004);
        rd(3'd6, d); check("R6 alm_hi", d, 16'h0000);

        // Vector table: staging in configuration mode, then commit
        for (int i = 0; i < NV; i++) begin
            if (VEC[i][20:19] == OP_WR) begin
                wr(VEC[i][18:16], VEC[i][15:0]);
            end else begin
                rd(VEC[i][18:16], d);
                check($sformatf("R4/R6 table step %0d", i), d, VEC[i][15:0]);
            end
        end

        // R2: reload 2, divider restarted at commit
        pulses(2);
        rd(3'd5, d); check("R2 no tick before third pulse", d, 16'h0005);
        pulses(1);
        rd(3'd5, d); check("R2 tick on third pulse", d, 16'h0006);
        rd(3'd0, d); check("R2 second flag", d[0], 1'b1);

        // R7 / R8: alarm at 7
        rd(3'd0, d); check("R7 alarm flag low at 6", d[1], 1'b0);
        pulses(3);
        rd(3'd0, d); check("R7 alarm flag at 7", d[1], 1'b1);
        check("R8 irq_alarm gated off", irq_alarm, 1'b0);
        wr(3'd1, 16'h0002);
        check("R8 irq_alarm enabled", irq_alarm, 1'b1);
        wr(3'd0, 16'h000E);
        rd(3'd0, d); check("R7 write 1 keeps alarm flag", d[1], 1'b1);
        check("R7 write 0 clears second flag", d[0], 1'b0);
        wr(3'd0, 16'h000D);
        rd(3'd0, d); check("R7 alarm flag cleared", d[1], 1'b0);
        check("R8 irq_alarm follows flag", irq_alarm, 1'b0);

        // R9: synchronised flag
        wr(3'd0, 16'h0007);
        rd(3'd0, d); check("R9 sync cleared", d[3], 1'b0);
        pulses(3);
        rd(3'd0, d); check("R9 sync set by tick", d[3], 1'b1);

        // R4: protected write outside configuration mode
        wr(3'd5, 16'h1234);
        wait_done();
        rd(3'd5, d); check("R4 write outside cfg ignored", d, 16'h0008);

        // R5: busy window length and dropped write
        wait_done();
        wr_raw(3'd1, 16'h0001);
        peek(3'd0, d); check("R5 busy cycle 1", d[5], 1'b0);
        wr_raw(3'd1, 16'h0004);
        peek(3'd0, d); check("R5 busy cycle 3", d[5], 1'b0);
        @(negedge clk);
        peek(3'd0, d); check("R5 done after window", d[5], 1'b1);
        rd(3'd1, d); check("R5 busy write dropped", d, 16'h0001);
        check("R8 irq_second", irq_second, 1'b1);

        // R3: wrap with reload 0
        wr(3'd0, 16'h0010);
        wr(3'd4, 16'hFFFF);
        wr(3'd5, 16'hFFFF);
        wr(3'd3, 16'h0000);
        wr(3'd0, 16'h0000);
        wr(3'd1, 16'h0004);
        rd(3'd4, d); check("R3 cnt_hi before wrap", d, 16'hFFFF);
        rd(3'd0, d); check("R3 overflow low before wrap", d[2], 1'b0);
        pulses(1);
        rd(3'd4, d); check("R3 cnt_hi wrapped", d, 16'h0000);
        rd(3'd5, d); check("R3 cnt_lo wrapped", d, 16'h0000);
        rd(3'd0, d); check("R3 overflow flag", d[2], 1'b1);
        check("R8 irq_overflow", irq_overflow, 1'b1);

        if (!finished) begin
            finished = 1'b1;
            summary();
            $finish;
        end
    end
endmodule